// File: doc/BRIEF.md
# Saturating 8-bit Add/Subtract Unit

This block adds or subtracts two 8-bit operands in pure combinational logic. It is meant for per-channel colour arithmetic. In that use, a result that wraps around would turn a bright pixel dark, or a dark pixel bright. The adder is a chain of one-bit full adders in which each carry is passed to the next stage. Subtraction feeds the inverted second operand into the chain with the first carry-in forced to 1.

Two select inputs control the operation. `op_sub` picks add (0) or subtract (1). `mode_signed` picks unsigned (0) or two's-complement (1) interpretation. The unit always presents the wrapped result. It also presents a clamped result that stays inside the representable range of the selected type: 0..255 for unsigned, -128..127 for signed. Two flags tell which clamp was applied, and a third flag reports that one of them was.

Top module: `sat_addsub`

## Requirements
- R1: With `op_sub`=0, `sum_raw` equals (a + b) mod 256 in both modes.
- R2: With `op_sub`=1, `sum_raw` equals (a - b) mod 256 in both modes.
- R3: Unsigned add (`mode_signed`=0, `op_sub`=0) whose true sum exceeds 255 gives `sat_out`=0xFF with `sat_high`=1.
- R4: Unsigned subtract with b greater than a (a borrow) gives `sat_out`=0x00 with `sat_low`=1.
- R5: In signed mode, an add of operands with opposite sign bits never raises `ovf`. A subtract of operands with equal sign bits never raises `ovf`.
- R6: Signed overflow with a's sign bit 0 (true result above 127) gives `sat_out`=0x7F with `sat_high`=1.
- R7: Signed overflow with a's sign bit 1 (true result below -128) gives `sat_out`=0x80 with `sat_low`=1.
- R8: When the true result is inside the range of the selected type, including exactly its minimum or maximum, `sat_out` equals `sum_raw` and `sat_high`, `sat_low` and `ovf` are all 0.
- R9: `sat_high` and `sat_low` are never 1 together, and `ovf` is 1 exactly when one of them is 1.
- R10: Unsigned examples: 128+64 gives 192, 128+128 gives 255, 32-16 gives 16, and 32-48 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 8 | First operand (minuend for subtract) |
| b | input | 8 | Second operand (subtrahend for subtract) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| mode_signed | input | 1 | 0 = unsigned, 1 = two's complement |
| sum_raw | output | 8 | Wrapped result |
| sat_out | output | 8 | Result clamped to the type's range |
| ovf | output | 1 | The true result lay outside the range |
| sat_high | output | 1 | Clamped to the maximum |
| sat_low | output | 1 | Clamped to the minimum |

## Verification
The bench aims at the edges of both ranges:
- 255+0 and 255+1 unsigned.
- An exact -128 sum in signed mode.
- 0-(-128) and -128-1 in signed mode.
- Equal operands subtracted.

A design that read the unsigned carry with the wrong polarity on subtract would clamp every valid difference to 0. A design that took signed overflow from the wrong carry pair would clamp harmless mixed-sign sums, or would let 100+50 wrap to a negative value. A design that picked the clamp direction from the wrapped result instead of from the operand would clamp toward the wrong end. A broad sweep over operand pairs in all four op/mode combinations, compared with integer arithmetic, catches any wrong stage in the carry chain.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int SAT_W = 8;

  typedef enum logic {
    ARITH_UNSIGNED = 1'b0,
    ARITH_SIGNED   = 1'b1
  } arith_e;

  // which clamp the range check selected
  typedef struct packed {
    logic hi;
    logic lo;
  } clamp_s;
endpackage

// File: rtl/sat_fa_cell.sv
module sat_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  logic xy;
  always_comb begin
    xy   = x_i ^ y_i;
    s_o  = xy ^ ci_i;
    co_o = (x_i & y_i) | (xy & ci_i);
  end
endmodule

// File: rtl/sat_ripple.sv
module sat_ripple #(
  parameter int W = sat_pkg::SAT_W
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_in_o,
  output logic         c_out_o
);
  localparam int MSB = W - 1;

  // each stage owns its carry; the next stage reads it by name
  for (genvar i = 0; i < W; i++) begin : stg
    logic ci;
    logic co;
    if (i == 0) begin : g_first
      assign ci = ci_i;
    end else begin : g_link
      assign ci = stg[i-1].co;
    end
    sat_fa_cell u_fa (
      .x_i  (x_i[i]),
      .y_i  (y_i[i]),
      .ci_i (ci),
      .s_o  (sum_o[i]),
      .co_o (co)
    );
  end

  assign c_msb_in_o = stg[MSB].ci;
  assign c_out_o    = stg[MSB].co;
endmodule

// File: rtl/sat_range_chk.sv
module sat_range_chk (
  input  sat_pkg::arith_e mode_i,
  input  logic            sub_i,
  input  logic            a_msb_i,
  input  logic            c_msb_in_i,
  input  logic            c_out_i,
  output sat_pkg::clamp_s clamp_o
);
  import sat_pkg::*;

  logic sgn_v;

  always_comb begin
    sgn_v   = c_out_i ^ c_msb_in_i;
    clamp_o = '0;
    if (mode_i == ARITH_SIGNED) begin
      // overflow direction follows the first operand's sign
      clamp_o.hi = sgn_v & ~a_msb_i;
      clamp_o.lo = sgn_v &  a_msb_i;
    end else if (sub_i) begin
      // missing carry out of the top stage means a borrow
      clamp_o.lo = ~c_out_i;
    end else begin
      clamp_o.hi = c_out_i;
    end
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W = sat_pkg::SAT_W
) (
  input  logic [W-1:0]    sum_i,
  input  sat_pkg::arith_e mode_i,
  input  sat_pkg::clamp_s clamp_i,
  output logic [W-1:0]    sat_o
);
  import sat_pkg::*;

  localparam logic [W-1:0] U_MAX = {W{1'b1}};
  localparam logic [W-1:0] U_MIN = {W{1'b0}};
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] lim_hi;
  logic [W-1:0] lim_lo;

  always_comb begin
    lim_hi = (mode_i == ARITH_SIGNED) ? S_MAX : U_MAX;
    lim_lo = (mode_i == ARITH_SIGNED) ? S_MIN : U_MIN;
    unique case (1'b1)
      clamp_i.hi: sat_o = lim_hi;
      clamp_i.lo: sat_o = lim_lo;
      default:    sat_o = sum_i;
    endcase
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = sat_pkg::SAT_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         op_sub,
  input  logic         mode_signed,
  output logic [W-1:0] sum_raw,
  output logic [W-1:0] sat_out,
  output logic         ovf,
  output logic         sat_high,
  output logic         sat_low
);
  import sat_pkg::*;

  arith_e       mode;
  logic [W-1:0] b_eff;
  logic         c_msb_in;
  logic         c_out;
  clamp_s       clamp;

  always_comb begin
    mode  = arith_e'(mode_signed);
    b_eff = op_sub ? ~b : b;
  end

  sat_ripple #(.W(W)) u_chain (
    .x_i        (a),
    .y_i        (b_eff),
    .ci_i       (op_sub),
    .sum_o      (sum_raw),
    .c_msb_in_o (c_msb_in),
    .c_out_o    (c_out)
  );

  sat_range_chk u_range (
    .mode_i     (mode),
    .sub_i      (op_sub),
    .a_msb_i    (a[W-1]),
    .c_msb_in_i (c_msb_in),
    .c_out_i    (c_out),
    .clamp_o    (clamp)
  );

  sat_clamp #(.W(W)) u_clamp (
    .sum_i   (sum_raw),
    .mode_i  (mode),
    .clamp_i (clamp),
    .sat_o   (sat_out)
  );

  assign sat_high = clamp.hi;
  assign sat_low  = clamp.lo;
  assign ovf      = clamp.hi | clamp.lo;
endmodule

// File: rtl/sat_addsub_chk.sv
module sat_addsub_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         op_sub,
  input logic         mode_signed,
  input logic [W-1:0] sum_raw,
  input logic [W-1:0] sat_out,
  input logic         ovf,
  input logic         sat_high,
  input logic         sat_low
);
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));
  localparam int UMAX = (1 << W) - 1;

  logic [W-1:0]        ref_add;
  logic [W-1:0]        ref_sub;
  logic [W:0]          u_add;
  logic signed [W+1:0] s_res;

  assign ref_add = a + b;
  assign ref_sub = a - b;
  assign u_add   = {1'b0, a} + {1'b0, b};
  assign s_res   = op_sub ? ($signed({{2{a[W-1]}}, a}) - $signed({{2{b[W-1]}}, b}))
                          : ($signed({{2{a[W-1]}}, a}) + $signed({{2{b[W-1]}}, b}));

  always_comb begin
    if (!op_sub)
      p_raw_add_r1: assert (sum_raw == ref_add) else $error("R1 raw add");
    if (op_sub)
      p_raw_sub_r2: assert (sum_raw == ref_sub) else $error("R2 raw sub");
    if (!mode_signed && !op_sub && (int'(u_add) > UMAX))
      p_uns_hi_r3: assert (sat_high && sat_out == {W{1'b1}}) else $error("R3");
    if (!mode_signed && op_sub && (b > a))
      p_uns_lo_r4: assert (sat_low && sat_out == '0) else $error("R4");
    if (mode_signed && ((!op_sub && a[W-1] != b[W-1]) || (op_sub && a[W-1] == b[W-1])))
      p_no_ovf_r5: assert (!ovf) else $error("R5");
    if (mode_signed && (s_res > SMAX))
      p_sgn_hi_r6: assert (sat_high && sat_out == {1'b0, {(W-1){1'b1}}}) else $error("R6");
    if (mode_signed && (s_res < SMIN))
      p_sgn_lo_r7: assert (sat_low && sat_out == {1'b1, {(W-1){1'b0}}}) else $error("R7");
    if (!ovf)
      p_pass_r8: assert (sat_out == sum_raw) else $error("R8");
    p_excl_r9: assert (!(sat_high && sat_low) && (ovf == (sat_high || sat_low)))
      else $error("R9");
  end
endmodule

bind sat_addsub sat_addsub_chk #(.W(W)) u_chk (
  .a           (a),
  .b           (b),
  .op_sub      (op_sub),
  .mode_signed (mode_signed),
  .sum_raw     (sum_raw),
  .sat_out     (sat_out),
  .ovf         (ovf),
  .sat_high    (sat_high),
  .sat_low     (sat_low)
);

// File: tb/sat_addsub_tb_top.sv
module sat_addsub_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] a, b;
  logic       op_sub, mode_signed;
  logic [7:0] sum_raw, sat_out;
  logic       ovf, sat_high, sat_low;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  sat_addsub dut_i (
    .a(a), .b(b), .op_sub(op_sub), .mode_signed(mode_signed),
    .sum_raw(sum_raw), .sat_out(sat_out), .ovf(ovf),
    .sat_high(sat_high), .sat_low(sat_low)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {req, op_sub, mode_signed, a, b, exp_sat, exp_hi, exp_lo}
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    {4'd10, 1'b0, 1'b0, 8'd128, 8'd64,  8'd192, 1'b0, 1'b0}, // R10
    {4'd10, 1'b0, 1'b0, 8'd128, 8'd128, 8'd255, 1'b1, 1'b0}, // R10
    {4'd10, 1'b1, 1'b0, 8'd32,  8'd16,  8'd16,  1'b0, 1'b0}, // R10
    {4'd10, 1'b1, 1'b0, 8'd32,  8'd48,  8'd0,   1'b0, 1'b1}, // R10
    {4'd3,  1'b0, 1'b0, 8'd200, 8'd100, 8'd255, 1'b1, 1'b0}, // R3
    {4'd8,  1'b0, 1'b0, 8'd255, 8'd0,   8'd255, 1'b0, 1'b0}, // R8
    {4'd3,  1'b0, 1'b0, 8'd255, 8'd1,   8'd255, 1'b1, 1'b0}, // R3
    {4'd4,  1'b1, 1'b0, 8'd0,   8'd1,   8'd0,   1'b0, 1'b1}, // R4
    {4'd8,  1'b1, 1'b0, 8'd5,   8'd5,   8'd0,   1'b0, 1'b0}, // R8
    {4'd6,  1'b0, 1'b1, 8'h64,  8'h32,  8'h7F,  1'b1, 1'b0}, // R6
    {4'd7,  1'b0, 1'b1, 8'h9C,  8'hCE,  8'h80,  1'b0, 1'b1}, // R7
    {4'd5,  1'b0, 1'b1, 8'h7F,  8'h80,  8'hFF,  1'b0, 1'b0}, // R5
    {4'd7,  1'b1, 1'b1, 8'h80,  8'h01,  8'h80,  1'b0, 1'b1}, // R7
    {4'd6,  1'b1, 1'b1, 8'h7F,  8'hFF,  8'h7F,  1'b1, 1'b0}, // R6
    {4'd5,  1'b1, 1'b1, 8'h80,  8'h80,  8'h00,  1'b0, 1'b0}, // R5
    {4'd6,  1'b0, 1'b1, 8'h7F,  8'h01,  8'h7F,  1'b1, 1'b0}, // R6
    {4'd6,  1'b1, 1'b1, 8'h00,  8'h80,  8'h7F,  1'b1, 1'b0}, // R6
    {4'd8,  1'b0, 1'b1, 8'hC0,  8'hC0,  8'h80,  1'b0, 1'b0}  // R8
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d sub=%0b sgn=%0b actual=%0d expected=%0d",
               tag, a, b, op_sub, mode_signed, act, exp);
    end
  endtask

  task automatic apply(input logic s, input logic m, input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    op_sub = s; mode_signed = m; a = x; b = y;
    #1;
  endtask

  // independent integer model of the requirements
  task automatic model(output int raw, output int sat, output int hi, output int lo);
    int ra, rb, r, mx, mn;
    ra = mode_signed ? int'($signed(a)) : int'(a);
    rb = mode_signed ? int'($signed(b)) : int'(b);
    r  = op_sub ? ra - rb : ra + rb;
    mx = mode_signed ? 127 : 255;
    mn = mode_signed ? -128 : 0;
    raw = r & 255;
    hi  = (r > mx) ? 1 : 0;
    lo  = (r < mn) ? 1 : 0;
    sat = hi ? (mx & 255) : (lo ? (mn & 255) : raw);
  endtask

  initial begin
    int raw, sat, hi, lo;
    rst_n = 1'b0; a = '0; b = '0; op_sub = 1'b0; mode_signed = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle state after reset: zero inputs give all-zero outputs (R8)
    #1;
    check("R8 idle sat", sat_out, 0);
    check("R9 idle ovf", ovf, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][27], VEC[i][26], VEC[i][25:18], VEC[i][17:10]);
      check($sformatf("R%0d vec%0d sat", VEC[i][31:28], i), sat_out, VEC[i][9:2]);
      check($sformatf("R%0d vec%0d hi", VEC[i][31:28], i), sat_high, VEC[i][1]);
      check($sformatf("R%0d vec%0d lo", VEC[i][31:28], i), sat_low, VEC[i][0]);
      check($sformatf("R9 vec%0d ovf", i), ovf, VEC[i][1] | VEC[i][0]);
    end

    // sweep all four op/mode pairs (R1 R2 R3 R4 R5 R6 R7 R8 R9)
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int x = 0; x < 256; x++) begin
          for (int y = 0; y < 256; y += 5) begin
            apply(s[0], m[0], x[7:0], y[7:0]);
            model(raw, sat, hi, lo);
            check(s ? "R2 raw" : "R1 raw", sum_raw, raw);
            check("R3/R4/R6/R7/R8 sat", sat_out, sat);
            check("R9 flags", {ovf, sat_high, sat_low}, {hi | lo, hi[0], lo[0]});
          end
        end
      end
    end

    // exact range limits, both ends (R8)
    apply(1'b0, 1'b1, 8'h40, 8'h3F);
    check("R8 signed max", {ovf, sat_out}, {1'b0, 8'h7F});
    apply(1'b1, 1'b0, 8'd255, 8'd255);
    check("R8 unsigned zero diff", {ovf, sat_out}, {1'b0, 8'h00});

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule